// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block connects a synchronous master to an external asynchronous static RAM of 512K words by 8 bits. The RAM has three active-low strobes: chip select, output enable and write enable. The master presents one request at a time. A request carries a 19-bit address, 8-bit write data and a read/write flag. The master holds the request until the controller returns a one-cycle ready pulse. For reads, the returned byte is valid during that ready cycle.

On the memory side, every strobe and every data-bus control is driven from a register. The strobes therefore change only on clock edges and cannot glitch. The controller drives its data bus through separate output and driver-enable lines. Reads and writes are built from whole clock periods. Each period count comes from a cycle parameter, which is rounded up so that the count times the clock period covers the matching memory time minimum.

Output enable stays high for the whole of every write. The memory's drivers are therefore never on while the controller drives data, and the shortest legal write pulse can be used. When a write follows a read, the controller inserts turnaround cycles before it turns its own drivers on.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, mem_cs_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0 and req_ready is 0.
- R2: An accepted read holds mem_addr at the request address with mem_cs_n=0, mem_oe_n=0, mem_we_n=1 and mem_dq_oe=0 for exactly RD_N cycles. It starts in the cycle after the accepting edge.
- R3: Read data is sampled from mem_dq_i on the edge that ends the last read cycle. It appears on rsp_rdata in the following cycle, in which all strobes are 1 and req_ready is 1.
- R4: req_ready is 1 for exactly one cycle per request and is otherwise 0.
- R5: A write has three phases, with mem_oe_n=1 in all of them and mem_dq_oe=1 in all of them:
  - one setup cycle with all strobes 1;
  - WP_N cycles with mem_cs_n=0 and mem_we_n=0;
  - one end cycle with all strobes 1 and req_ready=1.
- R6: During a write, mem_addr and mem_dq_o hold the request address and data from the setup cycle through the end cycle. They do not change while mem_we_n is 0.
- R7: A write whose previous operation was a read is preceded by TA_N cycles with all strobes 1 and mem_dq_oe=0. A write after a write, or the first operation after reset, has no such cycles.
- R8: RD_N, WP_N and TA_N each equal the larger of their cycle parameter and ceil(time minimum / CLK_PS), and are at least 1. The time minimums are T_RD_PS, T_WP_PS and T_TA_PS.
- R9: mem_dq_oe is never 1 while mem_oe_n is 0. mem_oe_n and mem_we_n are never 0 together.
- R10: A request is accepted only in idle. After each completion there is one idle cycle with all strobes 1, mem_dq_oe=0 and req_ready=0. This holds even when req_valid stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until req_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid while req_ready follows a read |
| mem_addr | output | 19 | Memory address bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_dq_i | input | 8 | Data seen on the memory bus |

## Verification
The assertions assume that the master keeps req_valid and the request fields steady from the cycle it raises req_valid until the ready cycle. They also assume that the memory responds to the strobes only as an asynchronous RAM does. The bench drives every request on the falling clock edge and changes the request only in the ready cycle. Its RAM model drives the bus only while chip and output enable are low with write enable high, and it commits a write only when the write-enable/chip-select overlap ends. Back-to-back requests keep req_valid high across the ready cycle, which exercises the idle gap. Parameter overrides let one count be set by its cycle parameter and another by rounding up of a time minimum.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RD_END,
        ST_TA,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_END
    } ctl_state_e;

    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
        logic dq_oe;
        logic ready;
    } pin_ctl_t;

    localparam pin_ctl_t PINS_IDLE = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0, ready: 1'b0};

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned cycles_for(input int unsigned cyc, input int unsigned t_ps,
                                               input int unsigned clk_ps);
        int unsigned need;
        need = ceil_div(t_ps, clk_ps);
        if (cyc > need) need = cyc;
        if (need == 0) need = 1;
        return need;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

    function automatic pin_ctl_t pins_for_state(input ctl_state_e s);
        pin_ctl_t p;
        p = PINS_IDLE;
        case (s)
            ST_RD:       begin p.cs_n = 1'b0; p.oe_n = 1'b0; end
            ST_RD_END:   p.ready = 1'b1;
            ST_WR_SETUP: p.dq_oe = 1'b1;
            ST_WR_PULSE: begin p.cs_n = 1'b0; p.we_n = 1'b0; p.dq_oe = 1'b1; end
            ST_WR_END:   begin p.dq_oe = 1'b1; p.ready = 1'b1; end
            default:     p = PINS_IDLE;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned RD_N  = 1,
    parameter int unsigned WP_N  = 1,
    parameter int unsigned TA_N  = 1,
    parameter int          CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             cnt_zero,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val,
    output logic             accept,
    output logic             capture,
    output pin_ctl_t         pins_q
);
    ctl_state_e st_q, st_d;
    logic       prev_rd_q;

    always_comb begin
        st_d     = st_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (!req_write) begin
                        st_d     = ST_RD;
                        cnt_load = 1'b1;
                        cnt_val  = CNT_W'(RD_N - 1);
                    end else if (prev_rd_q) begin
                        st_d     = ST_TA;
                        cnt_load = 1'b1;
                        cnt_val  = CNT_W'(TA_N - 1);
                    end else begin
                        st_d = ST_WR_SETUP;
                    end
                end
            end
            ST_RD: begin
                if (cnt_zero) begin
                    capture = 1'b1;
                    st_d    = ST_RD_END;
                end
            end
            ST_RD_END: st_d = ST_IDLE;
            ST_TA: begin
                if (cnt_zero) st_d = ST_WR_SETUP;
            end
            ST_WR_SETUP: begin
                st_d     = ST_WR_PULSE;
                cnt_load = 1'b1;
                cnt_val  = CNT_W'(WP_N - 1);
            end
            ST_WR_PULSE: begin
                if (cnt_zero) st_d = ST_WR_END;
            end
            ST_WR_END: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            pins_q    <= PINS_IDLE;
            prev_rd_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            pins_q <= pins_for_state(st_d);
            if (st_q == ST_RD_END) prev_rd_q <= 1'b1;
            else if (st_q == ST_WR_END) prev_rd_q <= 1'b0;
        end
    end

    // Write-pulse length tracker for the pulse-width check
    logic [15:0] we_len_q;
    always_ff @(posedge clk) begin
        if (rst) we_len_q <= '0;
        else if (!pins_q.we_n) we_len_q <= (we_len_q == 16'hFFFF) ? we_len_q : we_len_q + 16'd1;
        else we_len_q <= '0;
    end

    assert_wp_len_R8: assert property (@(posedge clk) disable iff (rst)
        (pins_q.we_n && !$past(pins_q.we_n)) |-> (we_len_q == 16'(WP_N)));

    assert_no_oe_we_overlap_R9: assert property (@(posedge clk) disable iff (rst)
        !(!pins_q.oe_n && !pins_q.we_n));

    assert_no_drive_under_oe_R9: assert property (@(posedge clk) disable iff (rst)
        pins_q.dq_oe |-> pins_q.oe_n);

    assert_read_strobes_R2: assert property (@(posedge clk) disable iff (rst)
        !pins_q.oe_n |-> (!pins_q.cs_n && pins_q.we_n && !pins_q.dq_oe));

    assert_write_strobes_R5: assert property (@(posedge clk) disable iff (rst)
        !pins_q.we_n |-> (!pins_q.cs_n && pins_q.oe_n && pins_q.dq_oe));

    assert_ready_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        pins_q.ready |=> !pins_q.ready);

    assert_drive_after_oe_high_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(pins_q.dq_oe) |-> $past(pins_q.oe_n));

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) rdata_q <= mem_dq_i;
        end
    end

    assert_no_accept_capture_R3: assert property (@(posedge clk) disable iff (rst)
        !(accept && capture));
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int DATA_W  = 8,
    parameter int CLK_PS  = 10000,
    parameter int RD_CYC  = 1,
    parameter int WP_CYC  = 1,
    parameter int TA_CYC  = 1,
    parameter int T_RD_PS = 10000,
    parameter int T_WP_PS = 8000,
    parameter int T_TA_PS = 5000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int unsigned RD_N  = cycles_for(RD_CYC, T_RD_PS, CLK_PS);
    localparam int unsigned WP_N  = cycles_for(WP_CYC, T_WP_PS, CLK_PS);
    localparam int unsigned TA_N  = cycles_for(TA_CYC, T_TA_PS, CLK_PS);
    localparam int unsigned MAX_N = max3(RD_N, WP_N, TA_N);
    localparam int          CNT_W = $clog2(MAX_N + 1);

    logic             cnt_load, cnt_zero, accept, capture;
    logic [CNT_W-1:0] cnt_val;
    pin_ctl_t         pins;

    sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    sram_ctrl_fsm #(
        .RD_N  (RD_N),
        .WP_N  (WP_N),
        .TA_N  (TA_N),
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .cnt_zero  (cnt_zero),
        .cnt_load  (cnt_load),
        .cnt_val   (cnt_val),
        .accept    (accept),
        .capture   (capture),
        .pins_q    (pins)
    );

    sram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_dq_i  (mem_dq_i),
        .addr_q    (mem_addr),
        .wdata_q   (mem_dq_o),
        .rdata_q   (rsp_rdata)
    );

    assign mem_cs_n  = pins.cs_n;
    assign mem_oe_n  = pins.oe_n;
    assign mem_we_n  = pins.we_n;
    assign mem_dq_oe = pins.dq_oe;
    assign req_ready = pins.ready;

    assert_write_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));

    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !req_ready));

endmodule

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb;
    localparam int CLK_PS  = 10000;
    localparam int RD_CYC  = 3;
    localparam int WP_CYC  = 1;
    localparam int TA_CYC  = 2;
    localparam int T_RD_PS = 10000;
    localparam int T_WP_PS = 15000;
    localparam int T_TA_PS = 5000;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [18:0] req_addr;
    logic [7:0]  req_wdata;
    logic        req_ready;
    logic [7:0]  rsp_rdata;
    logic [18:0] mem_addr;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_o;
    logic [7:0]  mem_dq_i;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sram_async_ctrl #(
        .CLK_PS(CLK_PS), .RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .TA_CYC(TA_CYC),
        .T_RD_PS(T_RD_PS), .T_WP_PS(T_WP_PS), .T_TA_PS(T_TA_PS)
    ) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // Counts from R8, computed independently
    function automatic int cyc_need(input int cyc, input int t_ps);
        int n;
        n = t_ps / CLK_PS;
        if (n * CLK_PS < t_ps) n = n + 1;
        if (cyc > n) n = cyc;
        if (n < 1) n = 1;
        return n;
    endfunction
    int rd_n, wp_n, ta_n;

    // Behavioural RAM: drives only when read-selected, commits at end of write overlap
    logic [7:0] ram [logic [18:0]];
    logic [7:0] exp_mem [logic [18:0]];
    logic       ram_drv;
    bit         pend = 0;
    logic [18:0] pa;
    logic [7:0]  pd;

    always @(*) begin
        ram_drv  = (!mem_cs_n && !mem_oe_n && mem_we_n);
        mem_dq_i = (ram_drv && ram.exists(mem_addr)) ? ram[mem_addr] : 8'h00;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (ram_drv && mem_dq_oe) begin
                nfail++;
                $display("FAIL R9: bus contention, dq_oe=%b ram_drv=%b expected no overlap", mem_dq_oe, ram_drv);
            end
            if (!mem_cs_n && !mem_we_n) begin
                pend = 1;
                pa = mem_addr;
                pd = mem_dq_o;
            end else if (pend) begin
                ram[pa] = pd;
                pend = 0;
            end
        end
    end

    // Expected pin tuples {cs_n, oe_n, we_n, dq_oe, ready}
    localparam logic [4:0] P_IDLE  = 5'b11100;
    localparam logic [4:0] P_RD    = 5'b00100;
    localparam logic [4:0] P_RDEND = 5'b11101;
    localparam logic [4:0] P_SETUP = 5'b11110;
    localparam logic [4:0] P_PULSE = 5'b01010;
    localparam logic [4:0] P_WREND = 5'b11111;

    bit after_end = 0;
    bit last_rd = 0;

    task automatic expect_cyc(input logic [4:0] e, input string tag,
                              input bit ca, input logic [18:0] a,
                              input bit cd, input logic [7:0] d);
        logic [4:0] got;
        @(negedge clk);
        got = {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready};
        nchk++;
        if (got !== e) begin
            nfail++;
            $display("FAIL %s: pins got %b expected %b at %0t", tag, got, e, $time);
        end
        if (ca) begin
            nchk++;
            if (mem_addr !== a) begin
                nfail++;
                $display("FAIL %s: mem_addr got %h expected %h", tag, mem_addr, a);
            end
        end
        if (cd) begin
            nchk++;
            if (mem_dq_o !== d) begin
                nfail++;
                $display("FAIL R6: mem_dq_o got %h expected %h", mem_dq_o, d);
            end
        end
    endtask

    task automatic do_op(input bit wr, input logic [18:0] a, input logic [7:0] d);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        // R10: request held across the ready cycle is not taken until idle
        if (after_end) expect_cyc(P_IDLE, "R10", 0, '0, 0, '0);
        if (!wr) begin
            for (int i = 0; i < rd_n; i++) expect_cyc(P_RD, "R2/R8", 1, a, 0, '0);
            expect_cyc(P_RDEND, "R3/R4", 0, '0, 0, '0);
            nchk++;
            if (rsp_rdata !== exp_mem[a]) begin
                nfail++;
                $display("FAIL R3: rsp_rdata got %h expected %h (addr %h)", rsp_rdata, exp_mem[a], a);
            end
            last_rd = 1;
        end else begin
            if (last_rd) for (int i = 0; i < ta_n; i++) expect_cyc(P_IDLE, "R7/R8", 0, '0, 0, '0);
            expect_cyc(P_SETUP, "R5/R7", 1, a, 1, d);
            for (int i = 0; i < wp_n; i++) expect_cyc(P_PULSE, "R5/R6/R8", 1, a, 1, d);
            expect_cyc(P_WREND, "R4/R5/R6", 1, a, 1, d);
            exp_mem[a] = d;
            last_rd = 0;
        end
        req_valid = 1'b0;
        after_end = 1;
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) expect_cyc(P_IDLE, "R10", 0, '0, 0, '0);
        after_end = 0;
    endtask

    initial begin
        rd_n = cyc_need(RD_CYC, T_RD_PS);
        wp_n = cyc_need(WP_CYC, T_WP_PS);
        ta_n = cyc_need(TA_CYC, T_TA_PS);
        rst = 1'b1;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr = '0;
        req_wdata = '0;
        repeat (4) @(negedge clk);
        // R1: reset state, checked while reset is still applied and after release
        nchk++;
        if ({mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready} !== P_IDLE) begin
            nfail++;
            $display("FAIL R1: pins got %b expected %b", {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready}, P_IDLE);
        end
        rst = 1'b0;
        expect_cyc(P_IDLE, "R1", 0, '0, 0, '0);

        do_op(1, 19'h00001, 8'h5A);   // first op: no turnaround (R7)
        do_op(1, 19'h7FFFF, 8'hA5);   // write after write: no turnaround
        do_op(0, 19'h00001, 8'h00);   // read
        do_op(1, 19'h12345, 8'h3C);   // write after read: turnaround
        do_op(0, 19'h7FFFF, 8'h00);
        do_op(0, 19'h12345, 8'h00);   // read after read
        gap(3);
        do_op(1, 19'h00000, 8'hFF);   // write after read with idle gap: still turnaround
        do_op(0, 19'h00000, 8'h00);
        gap(1);
        for (int i = 0; i < 8; i++) do_op(1, 19'(i * 20011 + 3), 8'(i * 29 + 7));
        for (int i = 0; i < 8; i++) begin
            do_op(0, 19'(i * 20011 + 3), 8'h00);
            do_op(1, 19'(i * 20011 + 3), 8'(i * 53 + 1));
        end
        for (int i = 0; i < 8; i++) do_op(0, 19'(i * 20011 + 3), 8'h00);
        gap(2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule